// File: doc/BRIEF.md
# Four-Entry Instruction Address Translation Buffer with Pairwise Replacement

The block holds four translation entries for instruction fetch and searches all of them in parallel. Each entry carries a virtual page number, an address-space identifier, a valid flag, a shared flag, a two-bit page-size code, a two-bit protection field, a cacheable flag and a physical page number. A lookup compares the fetch address with every entry at once. The block then reports one of three outcomes: a single hit with its slot index, the translated physical address and the page attributes; a miss; or a multiple hit.

Replacement uses a six-bit pairwise-ordering state. Every use of a slot changes this state through fixed clear and set masks. The victim slot comes from a fixed list of bit patterns that are tested in priority order. A refill port writes a complete entry into the slot that is the victim at that moment, and it counts as a use of that slot. The six state bits are exposed as `lruState`. They are bits [31:26] of a wider control word, so `lruState[k]` is bit k+2 of that word's top byte. All masks below are written on that byte.

Top module: `itlb4_plru`

## Requirements
- R1: After reset all four entries are invalid, `lruState` is 0 and `victimIdx` is 3. A lookup then misses, even at address 0.
- R2: An entry takes part in a match only if it is valid. Its identifier must also equal `curAsid`, unless the entry is shared or identifier checking is off. Checking is off only when `singleVirt` and `privMode` are both 1.
- R3: Size codes 0, 1, 2 and 3 select 1 KB, 4 KB, 64 KB and 1 MB pages. A page starts at the stored VPN shifted left by 10, with the offset bits of its size cleared. The low VPN bits that fall inside the page are ignored.
- R4: On a hit, `physAddr` takes the stored PPN shifted left by 10 with the page offset bits cleared, ORed with the address's own offset bits. `hitProt` and `hitCache` give the fields of the hit entry.
- R5: While `lookupEn` is 1 and `refillEn` is 0, exactly one of `hit`, `miss` and `multiHit` is 1. `multiHit` is 1 when two or more entries match, and `hit` is then 0. When `lookupEn` is 0, all three are 0.
- R6: A single hit on slot i updates the byte B = {lruState, 2'b00} at the next edge. For slot 0 it clears with 0x1F. For slot 1 it clears with 0xE7 and sets 0x80. For slot 2 it clears with 0xFB and sets 0x50. For slot 3 it sets 0x2C.
- R7: `victimIdx` is the first slot whose pattern matches B. Slot 0 matches when B&0xE0 is 0xE0, slot 1 when B&0x98 is 0x18, slot 2 when B&0x54 is 0x04, and slot 3 when B&0x2C is 0.
- R8: When `refillEn` is 1, the fill fields are written into slot `victimIdx` at the edge, and `lruState` is updated as for a use of that slot.
- R9: A refill takes priority over a lookup in the same cycle. All three lookup outputs are 0, and only the refill's state update takes effect.
- R10: A miss or a multiple hit leaves `lruState` unchanged.
- R11: `lruErr` is 1 only when B matches none of the four patterns, and the victim is then slot 0. This state cannot be reached from reset, so `lruErr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupEn | input | 1 | Request a translation of `lookupVa` |
| lookupVa | input | 32 | Virtual fetch address |
| curAsid | input | 8 | Current address-space identifier |
| privMode | input | 1 | Core is in privileged mode |
| singleVirt | input | 1 | Single virtual space mode |
| refillEn | input | 1 | Write the fill fields into the victim slot |
| fillVpn | input | 22 | Fill virtual page number |
| fillAsid | input | 8 | Fill identifier |
| fillValid | input | 1 | Fill valid flag |
| fillShared | input | 1 | Fill shared flag |
| fillSize | input | 2 | Fill page-size code |
| fillProt | input | 2 | Fill protection field |
| fillCache | input | 1 | Fill cacheable flag |
| fillPpn | input | 19 | Fill physical page number |
| hit | output | 1 | Exactly one entry matched |
| miss | output | 1 | No entry matched |
| multiHit | output | 1 | Two or more entries matched |
| hitIdx | output | 2 | Slot of the hit |
| physAddr | output | 29 | Translated address, 0 unless hit |
| hitProt | output | 2 | Protection of the hit entry |
| hitCache | output | 1 | Cacheable flag of the hit entry |
| victimIdx | output | 2 | Slot the next refill will write |
| lruState | output | 6 | Replacement state bits |
| lruErr | output | 1 | State matches no victim pattern |

## Verification
A refill and a lookup that would hit can be presented in the same cycle. Both would change the replacement state. The bench drives a refill of an invalid entry into the victim slot together with a lookup that would hit another slot. In that cycle it checks that all lookup outputs stay low. After the edge it checks that `lruState` holds exactly the value given by the refill slot's masks, and that the overwritten entry no longer translates.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  parameter int VA_W       = 32;
  parameter int PAGE_SHIFT = 10;
  parameter int VPN_W      = VA_W - PAGE_SHIFT;
  parameter int PPN_W      = 19;
  parameter int PA_W       = PPN_W + PAGE_SHIFT;
  parameter int ASID_W     = 8;
  parameter int N_ENT      = 4;
  parameter int IDX_W      = $clog2(N_ENT);
  parameter int LRU_W      = 6;

  // Per-slot masks on the top control byte (state sits in byte bits 7:2)
  parameter logic [7:0] USE_CLR [N_ENT] = '{8'h1F, 8'hE7, 8'hFB, 8'hFF};
  parameter logic [7:0] USE_SET [N_ENT] = '{8'h00, 8'h80, 8'h50, 8'h2C};
  parameter logic [7:0] VIC_SEL [N_ENT] = '{8'hE0, 8'h98, 8'h54, 8'h2C};
  parameter logic [7:0] VIC_VAL [N_ENT] = '{8'hE0, 8'h18, 8'h04, 8'h00};

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [1:0]        size;
    logic [1:0]        prot;
    logic              cache;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlbEntry_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } itlbStrobe_t;

  // Page-number bits kept for comparison, per size code
  function automatic logic [VPN_W-1:0] vpnKeep(input logic [1:0] sz);
    case (sz)
      2'd0:    return '1;
      2'd1:    return ~VPN_W'(3);
      2'd2:    return ~VPN_W'(63);
      default: return ~VPN_W'(1023);
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lruUse(input logic [LRU_W-1:0] s,
                                              input logic [IDX_W-1:0] i);
    logic [7:0] b;
    b = ({s, 2'b00} & USE_CLR[i]) | USE_SET[i];
    return b[7:2];
  endfunction
endpackage

// File: rtl/itlb_data.sv
module itlb_data
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  itlbStrobe_t       strobe,
  input  tlbEntry_t         fillEntry,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              useAsid,
  output logic [N_ENT-1:0]  matchVec,
  output tlbEntry_t         rdEntry,
  output logic [PA_W-1:0]   rdPhys
);
  tlbEntry_t ents [N_ENT];
  logic [VPN_W-1:0] vaVpn;
  logic [PPN_W-1:0] ppnKeep;

  assign vaVpn = lookupVa[VA_W-1:PAGE_SHIFT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
    end else if (strobe.wrEn) begin
      ents[strobe.wrIdx] <= fillEntry;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : gMatch
    logic [VPN_W-1:0] keep;
    logic asidOk;
    assign keep   = vpnKeep(ents[g].size);
    assign asidOk = !useAsid || ents[g].shared || (ents[g].asid == curAsid);
    assign matchVec[g] = ents[g].valid && asidOk &&
                         ((vaVpn & keep) == (ents[g].vpn & keep));
  end

  always_comb begin
    rdEntry = ents[strobe.rdIdx];
    ppnKeep = vpnKeep(rdEntry.size)[PPN_W-1:0];
    rdPhys  = {(rdEntry.ppn & ppnKeep) | (lookupVa[PA_W-1:PAGE_SHIFT] & ~ppnKeep),
               lookupVa[PAGE_SHIFT-1:0]};
  end
endmodule

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupEn,
  input  logic             refillEn,
  input  logic [N_ENT-1:0] matchVec,
  output itlbStrobe_t      strobe,
  output logic             hit,
  output logic             miss,
  output logic             multiHit,
  output logic [IDX_W-1:0] hitIdx,
  output logic [IDX_W-1:0] victimIdx,
  output logic [LRU_W-1:0] lruState,
  output logic             lruErr
);
  logic       lookAct;
  logic [7:0] ctlByte;
  int         nMatch;

  assign lookAct = lookupEn && !refillEn;
  assign ctlByte = {lruState, 2'b00};

  always_comb begin
    nMatch = $countones(matchVec);
    hitIdx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (matchVec[i]) hitIdx = IDX_W'(i);
    hit      = lookAct && (nMatch == 1);
    multiHit = lookAct && (nMatch > 1);
    miss     = lookAct && (nMatch == 0);
  end

  always_comb begin
    victimIdx = '0;
    lruErr    = 1'b1;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if ((ctlByte & VIC_SEL[i]) == VIC_VAL[i]) begin
        victimIdx = IDX_W'(i);
        lruErr    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         lruState <= '0;
    else if (refillEn) lruState <= lruUse(lruState, victimIdx);
    else if (hit)      lruState <= lruUse(lruState, hitIdx);
  end

  always_comb begin
    strobe.wrEn  = refillEn;
    strobe.wrIdx = victimIdx;
    strobe.rdIdx = hitIdx;
  end
endmodule

// File: rtl/itlb4_plru.sv
module itlb4_plru
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupEn,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              privMode,
  input  logic              singleVirt,
  input  logic              refillEn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillValid,
  input  logic              fillShared,
  input  logic [1:0]        fillSize,
  input  logic [1:0]        fillProt,
  input  logic              fillCache,
  input  logic [PPN_W-1:0]  fillPpn,
  output logic              hit,
  output logic              miss,
  output logic              multiHit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [PA_W-1:0]   physAddr,
  output logic [1:0]        hitProt,
  output logic              hitCache,
  output logic [IDX_W-1:0]  victimIdx,
  output logic [LRU_W-1:0]  lruState,
  output logic              lruErr
);
  itlbStrobe_t      strobe;
  tlbEntry_t        fillEntry, rdEntry;
  logic [N_ENT-1:0] matchVec;
  logic [PA_W-1:0]  rdPhys;
  logic             useAsid;

  assign useAsid = !(singleVirt && privMode);

  always_comb begin
    fillEntry.valid  = fillValid;
    fillEntry.shared = fillShared;
    fillEntry.size   = fillSize;
    fillEntry.prot   = fillProt;
    fillEntry.cache  = fillCache;
    fillEntry.asid   = fillAsid;
    fillEntry.vpn    = fillVpn;
    fillEntry.ppn    = fillPpn;
  end

  itlb_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillEntry(fillEntry),
    .lookupVa(lookupVa), .curAsid(curAsid), .useAsid(useAsid),
    .matchVec(matchVec), .rdEntry(rdEntry), .rdPhys(rdPhys)
  );

  itlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lookupEn(lookupEn), .refillEn(refillEn),
    .matchVec(matchVec), .strobe(strobe), .hit(hit), .miss(miss),
    .multiHit(multiHit), .hitIdx(hitIdx), .victimIdx(victimIdx),
    .lruState(lruState), .lruErr(lruErr)
  );

  assign physAddr = hit ? rdPhys : '0;
  assign hitProt  = hit ? rdEntry.prot : 2'b00;
  assign hitCache = hit && rdEntry.cache;
endmodule

// File: rtl/itlb4_plru_chk.sv
module itlb4_plru_chk
  import itlb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             lookupEn,
  input logic             refillEn,
  input logic             hit,
  input logic             miss,
  input logic             multiHit,
  input logic [IDX_W-1:0] hitIdx,
  input logic [IDX_W-1:0] victimIdx,
  input logic [LRU_W-1:0] lruState,
  input logic             lruErr
);
  // R5: one outcome per active lookup
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lookupEn && !refillEn) |-> $countones({hit, miss, multiHit}) == 1);

  // R5: idle lookup reports nothing
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !lookupEn |-> !(hit || miss || multiHit));

  // R9: refill suppresses lookup outcome
  p_refill_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    refillEn |-> !(hit || miss || multiHit));

  // R6: a just-hit slot is never the next victim
  p_hit_not_victim_r6: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> victimIdx != $past(hitIdx));

  // R8: a just-filled slot is never the next victim
  p_fill_moves_victim_r8: assert property (@(posedge clk) disable iff (!rstN)
    refillEn |=> victimIdx != $past(victimIdx));

  // R10: miss and multiple hit keep the state
  p_miss_keeps_state_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((miss || multiHit) && !refillEn) |=> $stable(lruState));

  // R11: the state always matches a victim pattern
  p_no_bad_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    !lruErr);
endmodule

bind itlb4_plru itlb4_plru_chk u_chk (.*);

// File: tb/sim_itlb4_plru.sv
`timescale 1ns/1ps
module sim_itlb4_plru;
  logic        clk = 1'b0;
  logic        rstN;
  logic        lookupEn, privMode, singleVirt, refillEn;
  logic [31:0] lookupVa;
  logic [7:0]  curAsid, fillAsid;
  logic [21:0] fillVpn;
  logic        fillValid, fillShared, fillCache;
  logic [1:0]  fillSize, fillProt;
  logic [18:0] fillPpn;
  logic        hit, miss, multiHit, hitCache, lruErr;
  logic [1:0]  hitIdx, victimIdx, hitProt;
  logic [28:0] physAddr;
  logic [5:0]  lruState;

  int nChk = 0, nBad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  itlb4_plru u0 (.*);

  // kind: 0 miss, 1 hit, 2 multiple
  typedef struct packed {
    logic [7:0]  asid;
    logic        priv;
    logic        sv;
    logic [31:0] va;
    logic [1:0]  kind;
    logic [1:0]  idx;
    logic [28:0] pa;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd5, 1'b0, 1'b0, 32'h0000_4123, 2'd1, 2'd3, 29'h0004_0123},  // R2 R4
    '{8'd5, 1'b0, 1'b0, 32'h0000_4400, 2'd0, 2'd0, 29'h0},          // R3 1K end
    '{8'd1, 1'b0, 1'b0, 32'h0018_2345, 2'd1, 2'd2, 29'h0028_2345},  // R2 shared, R3 1M
    '{8'd5, 1'b0, 1'b0, 32'h0002_FFFF, 2'd1, 2'd1, 29'h0001_FFFF},  // R3 64K
    '{8'd6, 1'b0, 1'b0, 32'h0002_0010, 2'd0, 2'd0, 29'h0},          // R2 asid diff
    '{8'd6, 1'b1, 1'b1, 32'h0002_0010, 2'd1, 2'd1, 29'h0001_0010},  // R2 check off
    '{8'd6, 1'b0, 1'b1, 32'h0002_0010, 2'd0, 2'd0, 29'h0},          // R2 user still checks
    '{8'd9, 1'b0, 1'b0, 32'h0000_5FFC, 2'd1, 2'd0, 29'h000C_0FFC},  // R3 4K low vpn ignored
    '{8'd9, 1'b0, 1'b0, 32'h0000_4010, 2'd0, 2'd0, 29'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lookupEn = 0; refillEn = 0;
  endtask

  // drive at negedge, outputs settle before the next posedge
  task automatic setLookup(input logic [7:0] a, input logic p, input logic s,
                           input logic [31:0] va);
    @(negedge clk);
    lookupEn = 1; curAsid = a; privMode = p; singleVirt = s; lookupVa = va;
    #1;
  endtask

  task automatic setFill(input logic [21:0] vpn, input logic [7:0] a, input logic v,
                         input logic sh, input logic [1:0] sz, input logic [1:0] pr,
                         input logic c, input logic [18:0] ppn);
    refillEn = 1; fillVpn = vpn; fillAsid = a; fillValid = v; fillShared = sh;
    fillSize = sz; fillProt = pr; fillCache = c; fillPpn = ppn;
  endtask

  task automatic refill(input logic [21:0] vpn, input logic [7:0] a, input logic v,
                        input logic sh, input logic [1:0] sz, input logic [1:0] pr,
                        input logic c, input logic [18:0] ppn);
    @(negedge clk);
    lookupEn = 0;
    setFill(vpn, a, v, sh, sz, pr, c, ppn);
    @(negedge clk);
    refillEn = 0;
    #1;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000 && !done) begin
        nBad++;
        $display("FAIL watchdog act=%0d exp=<5000", cyc);
        $display("test done: total=%0d bad=%0d", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    rstN = 0; idle(); privMode = 0; singleVirt = 0; curAsid = 0; lookupVa = 0;
    setFill(0, 0, 0, 0, 0, 0, 0, 0); refillEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 lruState", 32'(lruState), 0);
    chk("R1 victimIdx", 32'(victimIdx), 3);
    setLookup(8'd0, 0, 0, 32'h0);
    chk("R1 miss at 0", {29'b0, hit, miss, multiHit}, 32'b010);

    // fills walk the victim order 3,2,1,0
    chk("R7 victim 3", 32'(victimIdx), 3);
    refill(22'h010, 8'd5, 1, 0, 2'd0, 2'd2, 1, 19'h00100);
    chk("R8 state after slot3", 32'(lruState), 32'h0B);
    chk("R7 victim 2", 32'(victimIdx), 2);
    refill(22'h400, 8'd7, 1, 1, 2'd3, 2'd1, 0, 19'h00800);
    chk("R8 state after slot2", 32'(lruState), 32'h1E);
    chk("R7 victim 1", 32'(victimIdx), 1);
    refill(22'h080, 8'd5, 1, 0, 2'd2, 2'd3, 1, 19'h00040);
    chk("R8 state after slot1", 32'(lruState), 32'h38);
    chk("R7 victim 0", 32'(victimIdx), 0);
    refill(22'h017, 8'd9, 1, 0, 2'd1, 2'd0, 1, 19'h00300);
    chk("R8 state after slot0", 32'(lruState), 32'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] expF;
      setLookup(VECS[i].asid, VECS[i].priv, VECS[i].sv, VECS[i].va);
      expF = (VECS[i].kind == 2'd1) ? 3'b100 : (VECS[i].kind == 2'd2) ? 3'b001 : 3'b010;
      chk("R2/R3/R5 outcome", {29'b0, hit, miss, multiHit}, {29'b0, expF});
      if (VECS[i].kind == 2'd1) begin
        chk("R2/R3 hitIdx", 32'(hitIdx), 32'(VECS[i].idx));
        chk("R4 physAddr", 32'(physAddr), 32'(VECS[i].pa));
      end
      chk("R11 lruErr", 32'(lruErr), 0);
    end
    @(negedge clk); idle(); #1;
    chk("R6 state after hits 3,2,1,1,0", 32'(lruState), 32'h00);
    chk("R7 victim after walk", 32'(victimIdx), 3);

    // R4 attributes, R6 single hit on slot 2
    setLookup(8'd1, 0, 0, 32'h0010_0000);
    chk("R4 pa slot2", 32'(physAddr), 32'h0020_0000);
    chk("R4 prot", 32'(hitProt), 1);
    chk("R4 cache", 32'(hitCache), 0);
    @(negedge clk); idle(); #1;
    chk("R6 use slot2", 32'(lruState), 32'h14);
    chk("R7 victim after slot2 use", 32'(victimIdx), 3);

    // overlapping entry in slot3 -> multiple hit
    refill(22'h014, 8'd9, 1, 0, 2'd0, 2'd2, 0, 19'h00001);
    chk("R8 state after overlap fill", 32'(lruState), 32'h1F);
    chk("R7 victim 1 from 0x1F", 32'(victimIdx), 1);
    setLookup(8'd9, 0, 0, 32'h0000_5010);
    chk("R5 multiple", {29'b0, hit, miss, multiHit}, 32'b001);
    @(negedge clk); idle(); #1;
    chk("R10 multiple keeps state", 32'(lruState), 32'h1F);
    setLookup(8'd3, 0, 0, 32'h9000_0000);
    chk("R10 miss flag", 32'(miss), 1);
    @(negedge clk); idle(); #1;
    chk("R10 miss keeps state", 32'(lruState), 32'h1F);

    // R9: refill of an invalid entry into slot1 with a lookup that would hit slot2
    @(negedge clk);
    lookupEn = 1; curAsid = 8'd1; privMode = 0; singleVirt = 0; lookupVa = 32'h0010_0000;
    setFill(22'h080, 8'd5, 0, 0, 2'd2, 2'd3, 1, 19'h00040);
    #1;
    chk("R9 outputs low", {29'b0, hit, miss, multiHit}, 32'b000);
    @(negedge clk); idle(); #1;
    chk("R9 only refill update", 32'(lruState), 32'h39);
    setLookup(8'd5, 0, 0, 32'h0002_0010);
    chk("R2 invalid slot does not match", 32'(miss), 1);
    @(negedge clk); idle(); #1;
    chk("R5 idle outputs", {29'b0, hit, miss, multiHit}, 32'b000);

    // reset mid-run
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1; #1;
    chk("R1 state after reset", 32'(lruState), 0);
    chk("R1 victim after reset", 32'(victimIdx), 3);
    setLookup(8'd1, 0, 0, 32'h0010_0000);
    chk("R1 entries cleared", 32'(miss), 1);
    chk("R11 lruErr end", 32'(lruErr), 0);
    @(negedge clk); idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule